// File: doc/BRIEF.md
# Board Interrupt Expander Register File

This block sits inside a board-level programmable device. It gathers five external interrupt sources into one active-low, level-sensitive summary line for a host processor. Each source passes through a synchronizer. Its rising edge sets a sticky status bit, and that bit stays set until software clears it. A per-bit mask decides which of the latched bits may pull the summary line low. A mask bit of one blocks its source.

The host reaches the block through a simple 16-bit word bus. The bus has a select, a write enable, a byte offset and write data, and the read data path is combinational. Besides the interrupt registers, the bus decodes these:
- a write-to-clear reset register;
- three fixed signature words, which software checks to confirm the board is present;
- a code-version word and a board identity word;
- an LED output register;
- a synchronized button input register;
- a module-reset output register.

Top module: `board_irq_regfile`

## Requirements
- R1: After reset the mask register reads 0x001F, the status register reads 0x0000, the LED and module-reset registers read 0x0000, and `irq_n` is high.
- R2: Offset 0x40 reads 0xAAAA, offset 0x48 reads 0x5555 and offset 0x58 reads 0xCAFE. Offset 0x50 reads the code-version parameter and offset 0x68 reads the board identity parameter.
- R3: A rising edge on `src_in[i]` sets status bit i on the third clock edge after the input changes. The bit order is: bit 0 Ethernet, bit 1 UART A, bit 2 UART B, bit 3 button A, bit 4 button B. A source held high does not set its bit again after the bit is cleared.
- R4: The status register at offset 0x10 reads the latched bits whatever the mask holds, and bits 15 to 5 read as zero.
- R5: `irq_n` is low exactly when some status bit is set and its mask bit is zero. A mask of 0x1F keeps `irq_n` high.
- R6: Writing to the reset register at offset 0x20 clears every status bit written as one and leaves the bits written as zero untouched. The reset register reads as zero.
- R7: When a rising edge and a clear reach the same status bit in the same cycle, the bit ends up set.
- R8: The mask register at offset 0x38 stores bits 4 to 0 of a write and reads its upper bits as zero.
- R9: The LED register at offset 0x00 (8 bits) and the module-reset register at offset 0x60 (8 bits) hold written data, read it back, and drive `led_out` and `mod_rst_out`.
- R10: Offset 0x08 reads `btn_in` after two synchronizing clock edges, zero-extended.
- R11: Any other offset reads as zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Bus access select |
| host_we | input | 1 | Write enable (with host_sel) |
| host_addr | input | 8 | Byte offset of the word |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, zero when not selected |
| src_in | input | 5 | Raw interrupt sources |
| btn_in | input | 2 | Raw button levels |
| led_out | output | 8 | LED register contents |
| mod_rst_out | output | 8 | Module-reset register contents |
| irq_n | output | 1 | Active-low summary interrupt |

## Verification
The bench builds the block with its default parameters: five sources, 16-bit data and an 8-bit offset space. At that size the offset space has only 256 entries, so every offset is swept. Every combination of the 32 latched status patterns with the 32 mask values is applied, and for each pair the expected summary level is computed arithmetically. A directed test lines up a clear with a rising edge on the same bit in the same cycle.

// File: rtl/board_irq_pkg.sv
package board_irq_pkg;
  localparam logic [7:0] OFF_LED    = 8'h00;
  localparam logic [7:0] OFF_BTN    = 8'h08;
  localparam logic [7:0] OFF_STATUS = 8'h10;
  localparam logic [7:0] OFF_CLEAR  = 8'h20;
  localparam logic [7:0] OFF_MASK   = 8'h38;
  localparam logic [7:0] OFF_SIG_A  = 8'h40;
  localparam logic [7:0] OFF_SIG_B  = 8'h48;
  localparam logic [7:0] OFF_VER    = 8'h50;
  localparam logic [7:0] OFF_SIG_C  = 8'h58;
  localparam logic [7:0] OFF_MODRST = 8'h60;
  localparam logic [7:0] OFF_ID     = 8'h68;

  localparam logic [15:0] SIG_A_WORD = 16'hAAAA;
  localparam logic [15:0] SIG_B_WORD = 16'h5555;
  localparam logic [15:0] SIG_C_WORD = 16'hCAFE;
endpackage

// File: rtl/brd_src_sync.sv
module brd_src_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q[0] <= '0;
    else        stg_q[0] <= d_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_q[s-1];
    end
  end

  assign d_sync = stg_q[STAGES-1];
endmodule

// File: rtl/brd_irq_core.sv
module brd_irq_core #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_sync,
  input  logic [N-1:0] clr_vec,
  input  logic         mask_we,
  input  logic [N-1:0] mask_wdata,
  output logic [N-1:0] src_rise,
  output logic [N-1:0] status,
  output logic [N-1:0] mask,
  output logic         irq_n
);
  logic [N-1:0] prev_q;
  logic [N-1:0] status_d;
  logic [N-1:0] mask_d;

  assign src_rise = src_sync & ~prev_q;

  always_comb begin
    status_d = (status & ~clr_vec) | src_rise;
    mask_d   = mask_we ? mask_wdata : mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      status <= '0;
      mask   <= '1;
    end else begin
      prev_q <= src_sync;
      status <= status_d;
      mask   <= mask_d;
    end
  end

  assign irq_n = ~|(status & ~mask);
endmodule

// File: rtl/brd_reg_decode.sv
module brd_reg_decode
  import board_irq_pkg::*;
#(
  parameter int          N        = 5,
  parameter int          DATA_W   = 16,
  parameter int          ADDR_W   = 8,
  parameter int          LED_W    = 8,
  parameter int          BTN_W    = 2,
  parameter int          MODRST_W = 8,
  parameter logic [15:0] CODE_VER = 16'h0103,
  parameter logic [15:0] BOARD_ID = 16'h0051
) (
  input  logic                sel,
  input  logic                we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [N-1:0]        status,
  input  logic [N-1:0]        mask,
  input  logic [LED_W-1:0]    led,
  input  logic [BTN_W-1:0]    btn,
  input  logic [MODRST_W-1:0] modrst,
  output logic [DATA_W-1:0]   rdata,
  output logic                mask_we,
  output logic                led_we,
  output logic                modrst_we,
  output logic [N-1:0]        clr_vec
);
  logic wr;
  assign wr = sel & we;

  always_comb begin
    mask_we   = wr && (addr == ADDR_W'(OFF_MASK));
    led_we    = wr && (addr == ADDR_W'(OFF_LED));
    modrst_we = wr && (addr == ADDR_W'(OFF_MODRST));
    clr_vec   = (wr && (addr == ADDR_W'(OFF_CLEAR))) ? wdata[N-1:0] : '0;
  end

  always_comb begin
    rdata = '0;
    if (sel) begin
      case (addr)
        ADDR_W'(OFF_LED):    rdata = DATA_W'(led);
        ADDR_W'(OFF_BTN):    rdata = DATA_W'(btn);
        ADDR_W'(OFF_STATUS): rdata = DATA_W'(status);
        ADDR_W'(OFF_MASK):   rdata = DATA_W'(mask);
        ADDR_W'(OFF_SIG_A):  rdata = DATA_W'(SIG_A_WORD);
        ADDR_W'(OFF_SIG_B):  rdata = DATA_W'(SIG_B_WORD);
        ADDR_W'(OFF_VER):    rdata = DATA_W'(CODE_VER);
        ADDR_W'(OFF_SIG_C):  rdata = DATA_W'(SIG_C_WORD);
        ADDR_W'(OFF_MODRST): rdata = DATA_W'(modrst);
        ADDR_W'(OFF_ID):     rdata = DATA_W'(BOARD_ID);
        default:             rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/board_irq_regfile.sv
module board_irq_regfile #(
  parameter int          N          = 5,
  parameter int          DATA_W     = 16,
  parameter int          ADDR_W     = 8,
  parameter int          LED_W      = 8,
  parameter int          BTN_W      = 2,
  parameter int          MODRST_W   = 8,
  parameter int          SYNC_DEPTH = 2,
  parameter logic [15:0] CODE_VER   = 16'h0103,
  parameter logic [15:0] BOARD_ID   = 16'h0051
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_sel,
  input  logic                host_we,
  input  logic [ADDR_W-1:0]   host_addr,
  input  logic [DATA_W-1:0]   host_wdata,
  output logic [DATA_W-1:0]   host_rdata,
  input  logic [N-1:0]        src_in,
  input  logic [BTN_W-1:0]    btn_in,
  output logic [LED_W-1:0]    led_out,
  output logic [MODRST_W-1:0] mod_rst_out,
  output logic                irq_n
);
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [N-1:0]        src_sync, src_rise, status, mask, clr_vec;
  logic [BTN_W-1:0]    btn_sync;
  logic                mask_we, led_we, modrst_we;
  logic [LED_W-1:0]    led_q, led_d;
  logic [MODRST_W-1:0] modrst_q, modrst_d;

  brd_src_sync #(.W(N), .STAGES(SYNC_DEPTH)) u_src_sync (
    .clk(clk), .rst_n(rst_sync_n), .d_in(src_in), .d_sync(src_sync));

  brd_src_sync #(.W(BTN_W), .STAGES(SYNC_DEPTH)) u_btn_sync (
    .clk(clk), .rst_n(rst_sync_n), .d_in(btn_in), .d_sync(btn_sync));

  brd_irq_core #(.N(N)) u_core (
    .clk(clk), .rst_n(rst_sync_n), .src_sync(src_sync), .clr_vec(clr_vec),
    .mask_we(mask_we), .mask_wdata(host_wdata[N-1:0]), .src_rise(src_rise),
    .status(status), .mask(mask), .irq_n(irq_n));

  brd_reg_decode #(
    .N(N), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LED_W(LED_W), .BTN_W(BTN_W),
    .MODRST_W(MODRST_W), .CODE_VER(CODE_VER), .BOARD_ID(BOARD_ID)
  ) u_dec (
    .sel(host_sel), .we(host_we), .addr(host_addr), .wdata(host_wdata),
    .status(status), .mask(mask), .led(led_q), .btn(btn_sync),
    .modrst(modrst_q), .rdata(host_rdata), .mask_we(mask_we),
    .led_we(led_we), .modrst_we(modrst_we), .clr_vec(clr_vec));

  always_comb begin
    led_d    = led_we    ? host_wdata[LED_W-1:0]    : led_q;
    modrst_d = modrst_we ? host_wdata[MODRST_W-1:0] : modrst_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      led_q    <= '0;
      modrst_q <= '0;
    end else begin
      led_q    <= led_d;
      modrst_q <= modrst_d;
    end
  end

  assign led_out     = led_q;
  assign mod_rst_out = modrst_q;
endmodule

// File: rtl/board_irq_chk.sv
module board_irq_chk #(
  parameter int N = 5
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] rise,
  input logic [N-1:0] clr,
  input logic [N-1:0] status,
  input logic [N-1:0] mask,
  input logic         mask_we,
  input logic         irq_n
);
  // R3: an edge always leaves its status bit set (R7: even against a clear)
  a_r3_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((status & $past(rise)) == $past(rise)));

  // R6: cleared bits without a coincident edge are zero afterwards
  a_r6_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    ((|clr) && (rise == '0)) |=> ((status & $past(clr)) == '0));

  // R3/R6: no edge and no clear leaves status unchanged
  a_r3_status_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise == '0) && (clr == '0)) |=> $stable(status));

  // R5: a fully set mask keeps the summary line released
  a_r5_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '1) |-> irq_n);

  // R8: the mask only moves on a mask write
  a_r8_mask_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask));
endmodule

bind board_irq_regfile board_irq_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .rise(src_rise), .clr(clr_vec),
  .status(status), .mask(mask), .mask_we(mask_we), .irq_n(irq_n));

// File: tb/tb_board_irq_regfile.sv
module tb_board_irq_regfile;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_sel, host_we;
  logic [7:0]  host_addr;
  logic [15:0] host_wdata;
  logic [15:0] host_rdata;
  logic [4:0]  src_in;
  logic [1:0]  btn_in;
  logic [7:0]  led_out, mod_rst_out;
  logic        irq_n;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] rv;

  localparam logic [15:0] VER = 16'h0103;
  localparam logic [15:0] BID = 16'h0051;

  always #10 clk = ~clk;

  board_irq_regfile dut (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .src_in(src_in), .btn_in(btn_in), .led_out(led_out),
    .mod_rst_out(mod_rst_out), .irq_n(irq_n));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk);
    @(negedge clk);
    host_sel = 1'b0; host_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_we = 1'b0; host_addr = a;
    #1 d = host_rdata;
    host_sel = 1'b0;
  endtask

  task automatic cycles(input int k);
    for (int i = 0; i < k; i++) @(posedge clk);
  endtask

  function automatic bit mapped(input logic [7:0] a);
    return a inside {8'h00, 8'h08, 8'h10, 8'h20, 8'h38, 8'h40, 8'h48,
                     8'h50, 8'h58, 8'h60, 8'h68};
  endfunction

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; host_sel = 0; host_we = 0; host_addr = 0; host_wdata = 0;
    src_in = 0; btn_in = 0;
    cycles(3);
    @(negedge clk) rst_n = 1'b1;
    cycles(3);

    // R1 reset state
    rd(8'h38, rv); check("R1 mask", rv, 16'h001F);
    rd(8'h10, rv); check("R1 status", rv, 16'h0000);
    rd(8'h00, rv); check("R1 led", rv, 16'h0000);
    rd(8'h60, rv); check("R1 modrst", rv, 16'h0000);
    check("R1 irq_n", {15'd0, irq_n}, 16'h0001);

    // R2 identification words
    rd(8'h40, rv); check("R2 sigA", rv, 16'hAAAA);
    rd(8'h48, rv); check("R2 sigB", rv, 16'h5555);
    rd(8'h58, rv); check("R2 sigC", rv, 16'hCAFE);
    rd(8'h50, rv); check("R2 ver", rv, VER);
    rd(8'h68, rv); check("R2 id", rv, BID);

    // R3 latency on bit 1 (UART A)
    @(negedge clk) src_in = 5'b00010;
    @(posedge clk); @(posedge clk);
    rd(8'h10, rv); check("R3 not yet", rv, 16'h0000);
    @(posedge clk);
    rd(8'h10, rv); check("R3 third edge", rv, 16'h0002);
    src_in = 5'b0; cycles(3);
    wr(8'h20, 16'hFFFF); wr(8'h20, 16'h0000);

    // R3 R4 R5 sweep of patterns x masks
    for (int p = 0; p < 32; p++) begin
      @(negedge clk) src_in = 5'b0;
      cycles(3);
      wr(8'h20, 16'hFFFF); wr(8'h20, 16'h0000);
      @(negedge clk) src_in = 5'(p);
      cycles(4);
      for (int m = 0; m < 32; m++) begin
        wr(8'h38, 16'(m));
        rd(8'h10, rv); if (m == 0 || m == 31) check("R4 status raw", rv, 16'(p));
        check("R5 irq_n", {15'd0, irq_n}, {15'd0, ((p & ~m & 31) == 0)});
      end
    end
    check("R5 full mask quiet", {15'd0, irq_n}, 16'h0001);

    // R6 clear behaviour, R3 held level does not re-set
    @(negedge clk) src_in = 5'b0; cycles(3);
    @(negedge clk) src_in = 5'h1F; cycles(4);
    wr(8'h20, 16'h0000);
    rd(8'h10, rv); check("R6 zero write keeps", rv, 16'h001F);
    wr(8'h20, 16'h0004); wr(8'h20, 16'h0000);
    rd(8'h10, rv); check("R6 clear bit2", rv, 16'h001B);
    rd(8'h20, rv); check("R6 reads zero", rv, 16'h0000);
    cycles(5);
    rd(8'h10, rv); check("R3 held no reset", rv, 16'h001B);

    // R7 set wins over same-cycle clear (bit 0)
    @(negedge clk) src_in = 5'b0; cycles(3);
    wr(8'h20, 16'hFFFF); wr(8'h20, 16'h0000);
    @(negedge clk) src_in = 5'b00001;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk); host_sel = 1; host_we = 1; host_addr = 8'h20; host_wdata = 16'h0001;
    @(posedge clk);
    @(negedge clk); host_sel = 0; host_we = 0;
    rd(8'h10, rv); check("R7 set wins", rv, 16'h0001);

    // R8 mask upper bits
    wr(8'h38, 16'hFFEA);
    rd(8'h38, rv); check("R8 mask trunc", rv, 16'h000A);

    // R9 LED and module reset
    wr(8'h00, 16'hA55A); rd(8'h00, rv); check("R9 led rd", rv, 16'h005A);
    check("R9 led_out", {8'd0, led_out}, 16'h005A);
    wr(8'h60, 16'h1233); rd(8'h60, rv); check("R9 modrst rd", rv, 16'h0033);
    check("R9 mod_rst_out", {8'd0, mod_rst_out}, 16'h0033);

    // R10 buttons
    @(negedge clk) btn_in = 2'b10;
    @(posedge clk); @(posedge clk);
    rd(8'h08, rv); check("R10 btn", rv, 16'h0002);
    @(negedge clk) btn_in = 2'b01; cycles(2);
    rd(8'h08, rv); check("R10 btn2", rv, 16'h0001);

    // R11 unmapped offsets
    @(negedge clk) src_in = 5'b0; cycles(3);
    for (int a = 0; a < 256; a++) begin
      if (!mapped(8'(a))) begin
        rd(8'(a), rv); check("R11 unmapped read", rv, 16'h0000);
        wr(8'(a), 16'hFFFF);
        rd(8'h38, rv); check("R11 mask kept", rv, 16'h000A);
        rd(8'h00, rv); check("R11 led kept", rv, 16'h005A);
        rd(8'h60, rv); check("R11 modrst kept", rv, 16'h0033);
        rd(8'h10, rv); check("R11 status kept", rv, 16'h0001);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule